// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block keeps the coherence state and data of every line in one private, direct-mapped cache that takes part in a write-back update protocol on a shared atomic bus. A line that is present is always valid. It is in one of four states. Two states mean this cache holds the only copy, one clean and one dirty. Two states mean the line may also live in other caches, one clean and one carrying the duty to write the line back to memory. When the processor writes a line that others may share, the new word is broadcast on the bus so that peer caches overwrite their copies in place. Memory is not written by such a broadcast.

The processor side offers a simple request and response port. The bus side issues read, update and writeback commands, each with an address and a data word. It samples a wired-OR shared line during its own commands and drives its share of that line while it observes commands from other caches. Data for a fill arrives on a read-data input. Bus arbitration and the source of fill data are outside the block. An observed command takes effect only while the controller has no transaction of its own in flight.

Top module: `dragon_ctrl`

## Requirements
- R1: After reset no line is present, `bus_cmd` is 0 (none), `rsp_valid` is low and `req_ready` is high. Bus command encoding: 0 none, 1 read, 2 update, 3 writeback.
- R2: A read that misses issues one read command for the request address. It fills the line clean-exclusive if `bus_shared_in` is low in that cycle and clean-shared if it is high, and returns the fill word.
- R3: A read that hits returns the stored word and issues no bus command.
- R4: A write that hits a clean-exclusive or dirty-exclusive line stores the word, makes the line dirty-exclusive and issues no bus command.
- R5: A write that hits a shared line issues one update command carrying the address and the new word. The line becomes dirty-shared if `bus_shared_in` is high in that cycle and dirty-exclusive if it is low. After the update, every copy of the address holds the same word.
- R6: An observed update to a present line replaces the stored word and leaves the line clean-shared.
- R7: `snp_shared` is high in the same cycle as an observed command whose address matches a present line, and low otherwise.
- R8: An observed read to a present line moves clean-exclusive to clean-shared and dirty-exclusive to dirty-shared, so the writeback duty is kept.
- R9: A miss whose victim is dirty (exclusive or shared) first issues a writeback with the victim address and word, and then the read. A clean victim is dropped with no writeback.
- R10: A write that misses reads the line first. If shared is high it then issues an update with the write word and ends dirty-shared; otherwise it ends dirty-exclusive with no update.
- R11: `req_ready` is low in every cycle in which `snp_valid` is high; observed commands take priority over processor requests.
- R12: An observed writeback, or an observed command whose address is not present, changes no state or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write word |
| req_ready | output | 1 | Request accepted at this edge when high |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read word (write word for writes) |
| bus_cmd | output | 2 | Issued bus command |
| bus_addr | output | ADDR_W | Address of the issued command |
| bus_wdata | output | DATA_W | Word of an update or writeback |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled during own commands |
| bus_rdata | input | DATA_W | Fill word during own read |
| snp_valid | input | 1 | Command from another cache is on the bus |
| snp_cmd | input | 2 | Observed command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Observed address |
| snp_data | input | DATA_W | Observed update word |
| snp_shared | output | 1 | This cache's contribution to the wired-OR shared line |

## Verification
A wrong stored state does not show up when it is entered. It appears on the next operation that depends on it. A line left clean that should be dirty loses its writeback at eviction. A line left exclusive that should be shared stays silent on a write where an update was due, so peers go stale. A line that wrongly claims sharing sends an update that nobody expected. The bench therefore follows each state change with a write or an eviction that exposes it within a few cycles, and compares every bus command and every response against a queue of predicted items. A corrupted word is caught when a later read returns it or when it is carried out on an update or a writeback.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

  typedef enum logic [1:0] {
    LS_EXCL   = 2'd0,
    LS_SCLEAN = 2'd1,
    LS_SDIRTY = 2'd2,
    LS_MOD    = 2'd3
  } line_state_t;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_READ   = 2'd1,
    BC_UPDATE = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_t;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_VICT,
    FS_WBACK,
    FS_READ,
    FS_UPD
  } fsm_t;

  function automatic logic is_dirty(line_state_t s);
    return (s == LS_MOD) || (s == LS_SDIRTY);
  endfunction

  function automatic logic is_shared(line_state_t s);
    return (s == LS_SCLEAN) || (s == LS_SDIRTY);
  endfunction

  function automatic line_state_t fill_state(logic shared);
    return shared ? LS_SCLEAN : LS_EXCL;
  endfunction

  function automatic line_state_t after_update(logic shared);
    return shared ? LS_SDIRTY : LS_MOD;
  endfunction

  function automatic line_state_t snoop_next(line_state_t s, bus_cmd_t c);
    line_state_t n;
    n = s;
    case (c)
      BC_READ: begin
        if (s == LS_EXCL) n = LS_SCLEAN;
        else if (s == LS_MOD) n = LS_SDIRTY;
      end
      BC_UPDATE: n = LS_SCLEAN;
      default: n = s;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dragon_tag_store.sv
module dragon_tag_store
  import dragon_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_state_t      wr_state,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_valid,
  output logic [TAG_W-1:0] a_tag,
  output line_state_t      a_state,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_valid,
  output logic [TAG_W-1:0] b_tag,
  output line_state_t      b_state
);
  localparam int LINES = 1 << IDX_W;

  logic        valid_q [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  line_state_t state_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) valid_q[i] <= 1'b0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]   <= wr_tag;
      state_q[wr_idx] <= wr_state;
    end
  end

  assign a_valid = valid_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_state = state_q[a_idx];
  assign b_valid = valid_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_state = state_q[b_idx];

endmodule

// File: rtl/dragon_data_ram.sv
module dragon_data_ram #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/dragon_snoop.sv
module dragon_snoop
  import dragon_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  line_state_t      line_state,
  output logic             hit,
  output logic             take_data,
  output line_state_t      next_state
);
  bus_cmd_t cmd;

  assign cmd        = bus_cmd_t'(snp_cmd);
  assign hit        = snp_valid && line_valid && (line_tag == snp_tag);
  assign take_data  = hit && (cmd == BC_UPDATE);
  assign next_state = snoop_next(line_state, cmd);

endmodule

// File: rtl/dragon_ctrl.sv
module dragon_ctrl
  import dragon_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_shared_in,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  output logic              snp_shared
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_t              fs_q;
  logic              lat_write;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;

  logic [IDX_W-1:0]  req_idx, lat_idx, snp_idx, a_idx;
  logic [TAG_W-1:0]  req_tag, lat_tag, snp_tag;

  logic              a_valid, b_valid;
  logic [TAG_W-1:0]  a_tag, b_tag;
  line_state_t       a_state, b_state;

  logic              snp_hit, snp_take;
  line_state_t       snp_next_st;
  logic              snp_apply;

  logic              tw_en;
  logic [IDX_W-1:0]  tw_idx;
  logic [TAG_W-1:0]  tw_tag;
  line_state_t       tw_state;
  logic              rw_en;
  logic [IDX_W-1:0]  rw_idx;
  logic [DATA_W-1:0] rw_data;
  logic [DATA_W-1:0] ram_q;

  bus_cmd_t          bus_cmd_q;
  logic [ADDR_W-1:0] bus_addr_q;
  logic [DATA_W-1:0] bus_data_q;
  logic              rsp_valid_q, rsp_from_ram;
  logic [DATA_W-1:0] rsp_q;

  logic              accept, p_hit;

  assign req_idx = req_addr[IDX_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:IDX_W];
  assign lat_idx = lat_addr[IDX_W-1:0];
  assign lat_tag = lat_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
  assign a_idx   = (fs_q == FS_IDLE) ? req_idx : lat_idx;

  assign req_ready = (fs_q == FS_IDLE) && !snp_valid;
  assign accept    = req_valid && req_ready;
  assign p_hit     = a_valid && (a_tag == req_tag);
  assign snp_apply = (fs_q == FS_IDLE) && snp_hit;

  dragon_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .wr_en(tw_en), .wr_idx(tw_idx), .wr_tag(tw_tag), .wr_state(tw_state),
    .a_idx(a_idx), .a_valid(a_valid), .a_tag(a_tag), .a_state(a_state),
    .b_idx(snp_idx), .b_valid(b_valid), .b_tag(b_tag), .b_state(b_state)
  );

  dragon_data_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .we(rw_en), .waddr(rw_idx), .wdata(rw_data),
    .raddr(a_idx), .rdata(ram_q)
  );

  dragon_snoop #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_tag),
    .line_valid(b_valid), .line_tag(b_tag), .line_state(b_state),
    .hit(snp_hit), .take_data(snp_take), .next_state(snp_next_st)
  );

  // Array write selection: observed commands first, then own FSM.
  always_comb begin
    tw_en    = 1'b0;
    tw_idx   = lat_idx;
    tw_tag   = lat_tag;
    tw_state = LS_EXCL;
    rw_en    = 1'b0;
    rw_idx   = lat_idx;
    rw_data  = lat_wdata;
    if (snp_apply) begin
      tw_en    = 1'b1;
      tw_idx   = snp_idx;
      tw_tag   = b_tag;
      tw_state = snp_next_st;
      rw_en    = snp_take;
      rw_idx   = snp_idx;
      rw_data  = snp_data;
    end else begin
      case (fs_q)
        FS_IDLE: begin
          if (accept && p_hit && req_write) begin
            rw_en   = 1'b1;
            rw_idx  = req_idx;
            rw_data = req_wdata;
            if (!is_shared(a_state)) begin
              tw_en    = 1'b1;
              tw_idx   = req_idx;
              tw_tag   = req_tag;
              tw_state = LS_MOD;
            end
          end
        end
        FS_READ: begin
          tw_en    = 1'b1;
          tw_state = (lat_write && !bus_shared_in) ? LS_MOD : fill_state(bus_shared_in);
          rw_en    = 1'b1;
          rw_data  = lat_write ? lat_wdata : bus_rdata;
        end
        FS_UPD: begin
          tw_en    = 1'b1;
          tw_state = after_update(bus_shared_in);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q         <= FS_IDLE;
      lat_write    <= 1'b0;
      lat_addr     <= '0;
      lat_wdata    <= '0;
      bus_cmd_q    <= BC_NONE;
      bus_addr_q   <= '0;
      bus_data_q   <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_from_ram <= 1'b0;
      rsp_q        <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (fs_q)
        FS_IDLE: begin
          if (accept) begin
            lat_write <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            if (p_hit) begin
              if (!req_write) begin
                rsp_valid_q  <= 1'b1;
                rsp_from_ram <= 1'b1;
              end else if (is_shared(a_state)) begin
                bus_cmd_q  <= BC_UPDATE;
                bus_addr_q <= req_addr;
                bus_data_q <= req_wdata;
                fs_q       <= FS_UPD;
              end else begin
                rsp_valid_q  <= 1'b1;
                rsp_from_ram <= 1'b0;
                rsp_q        <= req_wdata;
              end
            end else if (a_valid && is_dirty(a_state)) begin
              fs_q <= FS_VICT;
            end else begin
              bus_cmd_q  <= BC_READ;
              bus_addr_q <= req_addr;
              fs_q       <= FS_READ;
            end
          end
        end
        FS_VICT: begin
          bus_cmd_q  <= BC_WBACK;
          bus_addr_q <= {a_tag, lat_idx};
          bus_data_q <= ram_q;
          fs_q       <= FS_WBACK;
        end
        FS_WBACK: begin
          bus_cmd_q  <= BC_READ;
          bus_addr_q <= lat_addr;
          fs_q       <= FS_READ;
        end
        FS_READ: begin
          if (lat_write && bus_shared_in) begin
            bus_cmd_q  <= BC_UPDATE;
            bus_data_q <= lat_wdata;
            fs_q       <= FS_UPD;
          end else begin
            bus_cmd_q    <= BC_NONE;
            fs_q         <= FS_IDLE;
            rsp_valid_q  <= 1'b1;
            rsp_from_ram <= 1'b0;
            rsp_q        <= lat_write ? lat_wdata : bus_rdata;
          end
        end
        FS_UPD: begin
          bus_cmd_q    <= BC_NONE;
          fs_q         <= FS_IDLE;
          rsp_valid_q  <= 1'b1;
          rsp_from_ram <= 1'b0;
          rsp_q        <= lat_wdata;
        end
        default: fs_q <= FS_IDLE;
      endcase
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_from_ram ? ram_q : rsp_q;
  assign bus_cmd    = bus_cmd_q;
  assign bus_addr   = bus_addr_q;
  assign bus_wdata  = bus_data_q;
  assign snp_shared = snp_hit;

endmodule

// File: rtl/dragon_ctrl_chk.sv
module dragon_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [1:0] bus_cmd,
  input logic       snp_valid,
  input logic       snp_shared
);

  assert_snoop_blocks_req_R11: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> !req_ready);

  assert_shared_needs_snoop_R7: assert property (@(posedge clk) disable iff (rst)
    !snp_valid |-> !snp_shared);

  assert_wback_then_read_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == 2'd3) |=> (bus_cmd == 2'd1));

  assert_update_then_rsp_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == 2'd2) |=> (rsp_valid && bus_cmd == 2'd0));

  assert_busy_no_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != 2'd0) |-> !req_ready);

  assert_read_then_upd_or_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == 2'd1) |=> (bus_cmd == 2'd2 || rsp_valid));

endmodule

bind dragon_ctrl dragon_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .bus_cmd(bus_cmd), .snp_valid(snp_valid), .snp_shared(snp_shared)
);

// File: tb/tb_dragon_ctrl.sv
module tb_dragon_ctrl;
  localparam int E = 0, SC = 1, SM = 2, M = 3;

  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  bus_cmd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        env_shared = 0;
  logic [31:0] env_fill = 0;
  logic        snp_valid = 0;
  logic [1:0]  snp_cmd = 0;
  logic [11:0] snp_addr = 0;
  logic [31:0] snp_data = 0;
  logic        snp_shared;

  always #5 clk = ~clk;

  dragon_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_shared_in(env_shared),
    .bus_rdata(env_fill), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_data(snp_data), .snp_shared(snp_shared)
  );

  typedef struct {
    bit        is_bus;
    bit [1:0]  cmd;
    bit [11:0] addr;
    bit [31:0] data;
    bit        chk_data;
    string     req;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit        rv [16];
  bit [7:0]  rt [16];
  int        rs [16];
  bit [31:0] rd [16];
  bit [31:0] peer [bit [11:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit b, input bit [1:0] c, input bit [11:0] a,
                      input bit [31:0] d, input bit cd, input string req);
    exp_t e;
    e.is_bus = b; e.cmd = c; e.addr = a; e.data = d; e.chk_data = cd; e.req = req;
    q.push_back(e);
  endtask

  // Monitor: pops predicted items as the design produces results.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (bus_cmd != 2'd0) begin
        if (q.size() == 0) chk(0, "bus", "unexpected command", {bus_cmd, bus_addr, bus_wdata}, 0);
        else begin
          cur = q.pop_front();
          chk(cur.is_bus && cur.cmd == bus_cmd && cur.addr == bus_addr &&
              (!cur.chk_data || cur.data == bus_wdata), cur.req, "bus command",
              {bus_cmd, bus_addr, bus_wdata}, {cur.cmd, cur.addr, cur.data});
          if (bus_cmd == 2'd2 && env_shared) peer[bus_addr] = bus_wdata;
        end
      end
      if (rsp_valid) begin
        if (q.size() == 0) chk(0, "rsp", "unexpected response", rsp_rdata, 0);
        else begin
          cur = q.pop_front();
          chk(!cur.is_bus && (!cur.chk_data || cur.data == rsp_rdata), cur.req,
              "response", rsp_rdata, cur.data);
        end
      end
    end
  end

  task automatic cpu(input bit wr, input bit [11:0] a, input bit [31:0] wd,
                     input bit sh, input bit [31:0] fill, input string req);
    int idx;
    idx = a[3:0];
    if (!(rv[idx] && rt[idx] == a[11:4])) begin
      if (rv[idx] && (rs[idx] == SM || rs[idx] == M))
        push(1, 2'd3, {rt[idx], a[3:0]}, rd[idx], 1, req);
      push(1, 2'd1, a, 0, 0, req);
      rv[idx] = 1; rt[idx] = a[11:4]; rd[idx] = fill; rs[idx] = sh ? SC : E;
    end
    if (wr) begin
      if (rs[idx] == E || rs[idx] == M) rs[idx] = M;
      else begin
        push(1, 2'd2, a, wd, 1, req);
        rs[idx] = sh ? SM : M;
      end
      rd[idx] = wd;
      push(0, 0, a, wd, 0, req);
    end else push(0, 0, a, rd[idx], 1, req);
    @(negedge clk);
    env_shared = sh; env_fill = fill;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    wait (q.size() == 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic snoop(input bit [1:0] c, input bit [11:0] a, input bit [31:0] d,
                       input string req);
    int idx;
    bit hit;
    idx = a[3:0];
    hit = rv[idx] && rt[idx] == a[11:4];
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a; snp_data = d;
    #1;
    chk(snp_shared == hit, {req, " R7"}, "shared line", snp_shared, hit);
    chk(!req_ready, "R11", "ready during observed command", req_ready, 0);
    @(negedge clk);
    snp_valid = 0;
    if (hit) begin
      if (c == 2'd1) begin
        if (rs[idx] == E) rs[idx] = SC;
        else if (rs[idx] == M) rs[idx] = SM;
      end else if (c == 2'd2) begin
        rd[idx] = d; rs[idx] = SC; peer[a] = d;
      end
    end
    @(negedge clk);
  endtask

  task automatic coherent(input bit [11:0] a, input string req);
    chk(peer.exists(a) && peer[a] == rd[a[3:0]], req, "peer copy equals local",
        peer.exists(a) ? peer[a] : 32'hx, rd[a[3:0]]);
    cpu(0, a, 0, 1, 0, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rv[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #1;
    chk(bus_cmd == 0, "R1", "bus idle after reset", bus_cmd, 0);
    chk(!rsp_valid, "R1", "no response after reset", rsp_valid, 0);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);

    cpu(0, 12'h010, 0, 0, 32'hA1A1_0001, "R1 R2 miss exclusive");
    cpu(0, 12'h010, 0, 0, 0, "R3 read hit");
    cpu(1, 12'h010, 32'h0000_0B01, 0, 0, "R4 write exclusive");
    snoop(2'd1, 12'h010, 0, "R8 observed read on dirty");
    cpu(1, 12'h010, 32'h0000_0B02, 1, 0, "R5 update shared");
    coherent(12'h010, "R5 coherence");
    cpu(0, 12'h110, 0, 0, 32'hBBBB_0110, "R9 dirty-shared eviction");
    snoop(2'd1, 12'h020, 0, "R12 absent line");
    snoop(2'd2, 12'h110, 32'hCAFE_0001, "R6 observed update");
    cpu(0, 12'h110, 0, 0, 0, "R6 read observed word");
    cpu(1, 12'h110, 32'h0000_0B03, 0, 0, "R5 update not shared");
    cpu(1, 12'h110, 32'h0000_0B04, 0, 0, "R4 write dirty");
    snoop(2'd2, 12'h110, 32'hCAFE_0002, "R6 update onto dirty");
    coherent(12'h110, "R6 coherence");
    cpu(0, 12'h210, 0, 0, 32'hDDDD_0210, "R9 clean eviction");
    cpu(1, 12'h033, 32'h0000_0B05, 1, 32'hF00D_0033, "R10 write miss shared");
    coherent(12'h033, "R10 coherence");
    cpu(1, 12'h044, 32'h0000_0B06, 0, 32'hF00D_0044, "R10 write miss alone");
    cpu(0, 12'h144, 0, 0, 32'hEEEE_0144, "R9 dirty eviction");
    snoop(2'd3, 12'h033, 32'h1234_5678, "R12 observed writeback");
    cpu(0, 12'h033, 0, 0, 0, "R12 data kept");
    cpu(0, 12'h133, 0, 0, 32'hEEEE_0133, "R12 duty kept");
    cpu(0, 12'h055, 0, 0, 32'h5555_0055, "R2 fill exclusive");
    snoop(2'd1, 12'h055, 0, "R8 observed read on clean");
    cpu(1, 12'h055, 32'h0000_0B07, 1, 0, "R8 write after demotion");
    cpu(0, 12'h0A7, 0, 1, 32'h7777_00A7, "R2 miss shared");
    cpu(1, 12'h0A7, 32'h0000_0B08, 1, 0, "R2 shared fill then update");
    snoop(2'd2, 12'h1A7, 32'hDEAD_BEEF, "R12 update absent tag");
    cpu(0, 12'h0A7, 0, 1, 0, "R12 word unchanged");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule